// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor that runs each instruction over several clock cycles. The memory and the ALU are shared across those cycles. A 4-bit state register steps through instruction fetch, decode, execution, memory access and register write-back. The datapath control strobes and mux selects are decoded from the current state alone, so the controls are Moore outputs.

After decode, the sequencer branches on the 6-bit opcode held by the datapath's instruction register. Five instruction kinds are supported: register-register ALU operations, word loads, word stores, branch-if-equal and unconditional jump. Depending on its kind, an instruction takes three, four or five cycles. When an opcode cannot be sequenced, the instruction is abandoned at once and a one-cycle illegal-instruction flag is raised.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the fetch state and clears the illegal flag. A reset in the middle of an instruction takes effect at the next clock edge.
- R2: In the fetch state, pc_wr, ir_wr and mem_rd are 1, addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00 and pc_src=00. The next state is always decode.
- R3: In the decode state, alu_a_sel=0, alu_b_sel=11 and alu_op=00. The next state is chosen by opcode: 000000 goes to ALU execute, 000010 to jump, 000100 to branch, and 100011 or 101011 to address compute.
- R4: In the address-compute state, alu_a_sel=1, alu_b_sel=10 and alu_op=00. Opcode 100011 goes next to load-read and opcode 101011 to store-write.
- R5: A load takes 5 cycles. Load-read drives mem_rd=1 and addr_sel=1. Load write-back drives rf_wr=1, rf_dst=0 and wb_sel=1 and then returns to fetch. The opcode has no effect once load-read is reached.
- R6: A store takes 4 cycles. Store-write drives mem_wr=1 and addr_sel=1 and then returns to fetch.
- R7: A register ALU instruction takes 4 cycles. Execute drives alu_a_sel=1, alu_b_sel=00 and alu_op=10. Write-back drives rf_wr=1, rf_dst=1 and wb_sel=0 and then returns to fetch.
- R8: A branch takes 3 cycles. Its last state drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_src=01 and pc_wr_cond=1.
- R9: A jump takes 3 cycles. Its last state drives pc_src=10 and pc_wr=1.
- R10: Every control that a state does not assign is 0, and mem_rd and mem_wr are never 1 together.
- R11: In decode, any opcode outside the five listed goes next to fetch. In address compute, an opcode other than 100011 or 101011 does the same. In both cases illegal is 1 for exactly that one following fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Opcode field of the held instruction |
| pc_wr_o | output | 1 | Unconditional program counter write |
| pc_wr_cond_o | output | 1 | Program counter write if ALU result is zero |
| addr_sel_o | output | 1 | Memory address source: 0 program counter, 1 ALU register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| ir_wr_o | output | 1 | Instruction register load |
| wb_sel_o | output | 1 | Register write data: 0 ALU register, 1 memory data register |
| pc_src_o | output | 2 | Next program counter source |
| alu_op_o | output | 2 | ALU operation class |
| alu_a_sel_o | output | 1 | ALU A operand select |
| alu_b_sel_o | output | 2 | ALU B operand select |
| rf_wr_o | output | 1 | Register file write strobe |
| rf_dst_o | output | 1 | Destination register field select |
| illegal_o | output | 1 | Unsupported opcode was abandoned |

## Verification
Each of the ten states drives its own distinct pattern on the control ports, so the bench can infer the state from the ports on every cycle. A wrong next state shows up one cycle later as the wrong control pattern. A wrong output decode shows up in the same cycle. The bench sweeps all 64 opcode values through a full instruction and compares every cycle, so a misrouted opcode is caught within two cycles of decode. A wrong cycle count is caught at the point where fetch should reappear.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OP_W = 6;
    localparam int ST_W = 4;
    localparam int SEL_W = 2;

    typedef enum logic [ST_W-1:0] {
        S_FETCH  = 4'd0,
        S_DECODE = 4'd1,
        S_ADDR   = 4'd2,
        S_LDMEM  = 4'd3,
        S_LDWB   = 4'd4,
        S_STMEM  = 4'd5,
        S_ALUEX  = 4'd6,
        S_ALUWB  = 4'd7,
        S_BRANCH = 4'd8,
        S_JUMP   = 4'd9
    } state_e;

    localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OP_STORE = 6'b101011;

    typedef struct packed {
        logic             pc_wr;
        logic             pc_wr_cond;
        logic             addr_sel;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_wr;
        logic             wb_sel;
        logic [SEL_W-1:0] pc_src;
        logic [SEL_W-1:0] alu_op;
        logic             alu_a_sel;
        logic [SEL_W-1:0] alu_b_sel;
        logic             rf_wr;
        logic             rf_dst;
    } ctrl_t;

    typedef struct packed {
        state_e nxt;
        logic   bad;
    } step_t;

    function automatic ctrl_t ctrl_of(state_e s);
        ctrl_t c;
        c = '0;
        case (s)
            S_FETCH: begin
                c.mem_rd    = 1'b1;
                c.ir_wr     = 1'b1;
                c.pc_wr     = 1'b1;
                c.alu_b_sel = 2'b01;
            end
            S_DECODE: c.alu_b_sel = 2'b11;
            S_ADDR: begin
                c.alu_a_sel = 1'b1;
                c.alu_b_sel = 2'b10;
            end
            S_LDMEM: begin
                c.mem_rd   = 1'b1;
                c.addr_sel = 1'b1;
            end
            S_LDWB: begin
                c.rf_wr  = 1'b1;
                c.wb_sel = 1'b1;
            end
            S_STMEM: begin
                c.mem_wr   = 1'b1;
                c.addr_sel = 1'b1;
            end
            S_ALUEX: begin
                c.alu_a_sel = 1'b1;
                c.alu_op    = 2'b10;
            end
            S_ALUWB: begin
                c.rf_wr  = 1'b1;
                c.rf_dst = 1'b1;
            end
            S_BRANCH: begin
                c.alu_a_sel  = 1'b1;
                c.alu_op     = 2'b01;
                c.pc_src     = 2'b01;
                c.pc_wr_cond = 1'b1;
            end
            S_JUMP: begin
                c.pc_src = 2'b10;
                c.pc_wr  = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic step_t next_of(state_e s, logic [OP_W-1:0] op);
        step_t r;
        r.nxt = S_FETCH;
        r.bad = 1'b0;
        case (s)
            S_FETCH: r.nxt = S_DECODE;
            S_DECODE: begin
                case (op)
                    OP_RTYPE:          r.nxt = S_ALUEX;
                    OP_JUMP:           r.nxt = S_JUMP;
                    OP_BEQ:            r.nxt = S_BRANCH;
                    OP_LOAD, OP_STORE: r.nxt = S_ADDR;
                    default:           r.bad = 1'b1;
                endcase
            end
            S_ADDR: begin
                case (op)
                    OP_LOAD:  r.nxt = S_LDMEM;
                    OP_STORE: r.nxt = S_STMEM;
                    default:  r.bad = 1'b1;
                endcase
            end
            S_LDMEM: r.nxt = S_LDWB;
            S_ALUEX: r.nxt = S_ALUWB;
            default: r.nxt = S_FETCH;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
    import mc_ctrl_pkg::*;
(
    input  state_e            cur_i,
    input  logic [OP_W-1:0]   opcode_i,
    output state_e            nxt_o,
    output logic              bad_o
);
    step_t step;

    always_comb begin
        step  = next_of(cur_i, opcode_i);
        nxt_o = step.nxt;
        bad_o = step.bad;
    end
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
    import mc_ctrl_pkg::*;
(
    input  state_e cur_i,
    output ctrl_t  ctrl_o
);
    always_comb ctrl_o = ctrl_of(cur_i);
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  opcode_i,
    output logic             pc_wr_o,
    output logic             pc_wr_cond_o,
    output logic             addr_sel_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             ir_wr_o,
    output logic             wb_sel_o,
    output logic [SEL_W-1:0] pc_src_o,
    output logic [SEL_W-1:0] alu_op_o,
    output logic             alu_a_sel_o,
    output logic [SEL_W-1:0] alu_b_sel_o,
    output logic             rf_wr_o,
    output logic             rf_dst_o,
    output logic             illegal_o
);
    state_e state_q;
    state_e state_d;
    logic   bad_d;
    logic   illegal_q;
    ctrl_t  ctrl;

    mc_ctrl_next u_next (
        .cur_i    (state_q),
        .opcode_i (opcode_i),
        .nxt_o    (state_d),
        .bad_o    (bad_d)
    );

    mc_ctrl_out u_out (
        .cur_i  (state_q),
        .ctrl_o (ctrl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_FETCH;
            illegal_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            illegal_q <= bad_d;
        end
    end

    assign pc_wr_o      = ctrl.pc_wr;
    assign pc_wr_cond_o = ctrl.pc_wr_cond;
    assign addr_sel_o   = ctrl.addr_sel;
    assign mem_rd_o     = ctrl.mem_rd;
    assign mem_wr_o     = ctrl.mem_wr;
    assign ir_wr_o      = ctrl.ir_wr;
    assign wb_sel_o     = ctrl.wb_sel;
    assign pc_src_o     = ctrl.pc_src;
    assign alu_op_o     = ctrl.alu_op;
    assign alu_a_sel_o  = ctrl.alu_a_sel;
    assign alu_b_sel_o  = ctrl.alu_b_sel;
    assign rf_wr_o      = ctrl.rf_wr;
    assign rf_dst_o     = ctrl.rf_dst;
    assign illegal_o    = illegal_q;

    // R2: fetch is always followed by decode
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FETCH) |=> (state_q == S_DECODE));

    // R3: a load or store opcode at decode leads to address compute
    a_r3_mem_dispatch: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DECODE && (opcode_i == OP_LOAD || opcode_i == OP_STORE))
        |=> (alu_b_sel_o == 2'b10 && alu_a_sel_o));

    // R5: load write-back only follows a load memory read
    a_r5_wb_after_read: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_o && !rf_dst_o) |-> ($past(state_q) == S_LDMEM));

    // R8: a conditional PC write ends the instruction
    a_r8_branch_ends: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond_o |=> (state_q == S_FETCH && ir_wr_o));

    // R10: no read and write strobe together
    a_r10_no_rw_clash: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o));

    // R11: the illegal flag appears only in fetch, right after decode or address compute
    a_r11_illegal_origin: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (state_q == S_FETCH &&
                       ($past(state_q) == S_DECODE || $past(state_q) == S_ADDR)));

endmodule

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel;
    logic [1:0] pc_src, alu_op, alu_b_sel;
    logic       alu_a_sel, rf_wr, rf_dst, illegal;

    int n_run = 0;
    int n_fail = 0;
    logic pend_ill = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_ctrl_fsm dut (
        .clk(clk), .rst(rst), .opcode_i(opcode),
        .pc_wr_o(pc_wr), .pc_wr_cond_o(pc_wr_cond), .addr_sel_o(addr_sel),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .ir_wr_o(ir_wr), .wb_sel_o(wb_sel),
        .pc_src_o(pc_src), .alu_op_o(alu_op), .alu_a_sel_o(alu_a_sel),
        .alu_b_sel_o(alu_b_sel), .rf_wr_o(rf_wr), .rf_dst_o(rf_dst),
        .illegal_o(illegal)
    );

    // bit order: pc_wr pc_wr_cond addr_sel mem_rd mem_wr ir_wr wb_sel
    //            pc_src[2] alu_op[2] alu_a alu_b[2] rf_wr rf_dst illegal
    function automatic logic [17:0] exp_vec(int s, logic ill);
        logic [17:0] v;
        case (s)
            0: v = {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,1'b0,2'b01,1'b0,1'b0,ill};
            1: v = {7'b0,2'b00,2'b00,1'b0,2'b11,1'b0,1'b0,1'b0};
            2: v = {7'b0,2'b00,2'b00,1'b1,2'b10,1'b0,1'b0,1'b0};
            3: v = {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0,1'b0};
            4: v = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,2'b00,1'b1,1'b0,1'b0};
            5: v = {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0,1'b0};
            6: v = {7'b0,2'b00,2'b10,1'b1,2'b00,1'b0,1'b0,1'b0};
            7: v = {7'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b1,1'b0};
            8: v = {1'b0,1'b1,5'b0,2'b01,2'b01,1'b1,2'b00,1'b0,1'b0,1'b0};
            9: v = {1'b1,6'b0,2'b10,2'b00,1'b0,2'b00,1'b0,1'b0,1'b0};
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(int s, logic ill, string req);
        logic [17:0] act;
        logic [17:0] exp;
        act = {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel,
               pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst, illegal};
        exp = exp_vec(s, ill);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b state%0d actual=%b expected=%b", req, opcode, s, act, exp);
        end
    endtask

    // one instruction from fetch back to the next fetch
    task automatic run_op(logic [5:0] op);
        opcode = op;
        check(0, pend_ill, "R2");
        tick();
        check(1, 1'b0, "R3");
        tick();
        pend_ill = 1'b0;
        case (op)
            6'b000000: begin check(6, 1'b0, "R7"); tick(); check(7, 1'b0, "R7"); tick(); end
            6'b000010: begin check(9, 1'b0, "R9"); tick(); end
            6'b000100: begin check(8, 1'b0, "R8"); tick(); end
            6'b100011: begin
                check(2, 1'b0, "R4"); tick();
                check(3, 1'b0, "R5"); tick();
                check(4, 1'b0, "R5"); tick();
            end
            6'b101011: begin
                check(2, 1'b0, "R4"); tick();
                check(5, 1'b0, "R6"); tick();
            end
            default: pend_ill = 1'b1; // R11: back in fetch with flag
        endcase
    endtask

    initial begin
        tick();
        tick();
        check(0, 1'b0, "R1");
        rst = 1'b0;
        // R2..R11: sweep every opcode value
        for (int op = 0; op < 64; op++) run_op(6'(op));
        // R11: flag lasts exactly one cycle
        check(0, 1'b1, "R11");
        opcode = 6'b000010;
        tick();
        check(1, 1'b0, "R11");
        tick();
        check(9, 1'b0, "R9");
        tick();
        pend_ill = 1'b0;
        // R11: non-memory opcode seen at address compute
        opcode = 6'b100011;
        check(0, 1'b0, "R2");
        tick();
        tick();
        check(2, 1'b0, "R4");
        opcode = 6'b000000;
        tick();
        check(0, 1'b1, "R11");
        // R5: opcode ignored once load-read is reached
        opcode = 6'b100011;
        tick();
        tick();
        check(2, 1'b0, "R4");
        tick();
        check(3, 1'b0, "R5");
        opcode = 6'b111111;
        tick();
        check(4, 1'b0, "R5");
        tick();
        check(0, 1'b0, "R5");
        // R1: reset in the middle of an ALU instruction
        opcode = 6'b000000;
        tick();
        tick();
        check(6, 1'b0, "R7");
        rst = 1'b1;
        tick();
        check(0, 1'b0, "R1");
        rst = 1'b0;
        tick();
        check(1, 1'b0, "R1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule